// File: doc/BRIEF.md
# Single-Phase Current-Source Bridge PWM Generator

This block produces the four gate commands for a single-phase current-source inverter bridge. A signed sinusoidal reference sample arrives on every clock; an internal up/down counter forms a symmetric triangular carrier whose half-period comes from an input word. In each carrier the captured reference is compared twice against the carrier, once directly and once mirrored, giving a voltage-source style pattern for two complementary legs. Cycles where that pattern would open the DC path are turned into shoot-through cycles. These cycles close a whole leg: the left leg while the reference is non-negative, the right leg otherwise. The result keeps the DC link current flowing and spreads conduction and switching over all four devices.

A mode input swaps in the simpler legacy scheme. In that scheme each half cycle holds one upper device on and modulates the two lower devices. The reference and the carrier period are taken only at the carrier valley, so every carrier stays symmetric. Gate outputs are registered and come up off after reset.

Top module: `csi_pwm_gen`

## Requirements
- R1: The carrier count starts at 0 in the first cycle after reset release. It rises by one per clock to the captured period P and then falls back to 0, so one carrier lasts 2P cycles. A period word below 2 is treated as 2.
- R2: The reference sample and the period word are captured only in a cycle where the carrier count is 0. A change at any other time has no effect until the next count of 0.
- R3: While reset is low, and in the first cycle after release, all four gates are 0.
- R4: In normal mode, with reference r (REF_W-bit two's complement), H = 2^(REF_W-1) and count c, the left level is floor((H+r)·P / 2^REF_W) and the right level is floor((H−r)·P / 2^REF_W). Upper gate g1 is 1 when the left level exceeds c and g3 is 1 when the right level exceeds c. The lower gates are g2 = not g1 and g4 = not g3.
- R5: A shoot-through cycle is any cycle with g1 and g3 both 0, or g2 and g4 both 0. In such a cycle, when r ≥ 0, both left-leg gates are forced on. When r < 0, both right-leg gates are forced on. Otherwise each gate equals its g value.
- R6: From the second cycle after reset release onward, at least one upper gate and at least one lower gate are on in every cycle.
- R7: In legacy mode, with m = floor(|r|·P / 2^(REF_W-1)) and w = (m > c): for r ≥ 0, S1 = 1, S3 = 0, S4 = w and S2 = not w. For r < 0, S3 = 1, S1 = 0, S2 = w and S4 = not w.
- R8: In normal mode at full-scale sine amplitude, the on-times of the four gates over one fundamental period differ by at most one carrier period.
- R9: In legacy mode each upper gate makes exactly one rising and one falling transition per fundamental period.
- R10: The gate output bits are S1 = bit 0, S2 = bit 1, S3 = bit 2 and S4 = bit 3. Each is registered, so a gate reflects the count and mode of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1 selects the legacy half-cycle scheme |
| ref_sample | input | REF_W | Signed sinusoidal reference sample |
| period | input | CNT_W | Carrier half-period in clocks |
| gate | output | 4 | Bridge gate commands S1..S4 |

## Verification
The properties assume that the period word is at least 2 and fits the counter, that the mode input changes only while reset is low or at clock edges, and that the reference stays inside its two's-complement range. The stimulus holds the period at small legal values, apart from one deliberate value of 1 that exercises the clamp. It drives the reference from a full-scale sine sampled once per carrier, with the phase offset by half a sample so that no sample is exactly zero. It updates the reference at the carrier top, so every update lands away from the capture point. Held extreme references at both ends of the range complete the sweep.

// File: rtl/csi_pwm_pkg.sv
// Shared constants and types for the current-source bridge modulator.
// Assumes a full bridge: two legs, each with one upper and one lower device.
package csi_pwm_pkg;
    localparam int NUM_LEGS = 2;
    localparam int NUM_GATES = 2 * NUM_LEGS;

    // Gate pair of one bridge leg.
    typedef struct packed {
        logic lo;
        logic hi;
    } leg_gate_t;
endpackage

// File: rtl/csi_pwm_carrier.sv
// Triangular carrier: counts 0 -> P -> 0 with one step per clock.
// The period word is clamped to at least 2 and taken only at the valley,
// so a carrier in progress is never distorted.
module csi_pwm_carrier #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic             valley_o
);
    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic             up_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_legal;
    logic [CNT_W-1:0] per_eff;

    // Valley detect and period selection for the current step.
    assign valley_o  = (cnt_q == '0);
    assign per_legal = (period_in < MIN_PER) ? MIN_PER : period_in;
    assign per_eff   = valley_o ? per_legal : per_q;

    // Period capture at the valley only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (valley_o) begin
            per_q <= per_legal;
        end
    end

    // Up/down count with turn-around at the top and at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            cnt_q <= cnt_q + ONE;
            if ((cnt_q + ONE) >= per_eff) begin
                up_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
                up_q <= 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign per_o = per_q;
endmodule

// File: rtl/csi_pwm_compare.sv
// Reference capture and carrier comparison.
// Captures the signed reference at the valley. It forms one level per leg,
// the left leg from +r and the right leg from -r, each scaled to the
// captured period, and compares it against the carrier. It also produces the
// magnitude comparison used by the legacy scheme, and the reference sign.
// Assumes the period input is the value captured at the same valley.
module csi_pwm_compare
    import csi_pwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valley,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic [CNT_W-1:0]        per,
    input  logic [CNT_W-1:0]        cnt,
    output logic [NUM_LEGS-1:0]     hi_on,
    output logic                    pos_o,
    output logic                    mag_pwm_o
);
    localparam int OFF_W  = REF_W + 1;
    localparam int EXT_W  = REF_W + 2;
    localparam int PROD_W = OFF_W + CNT_W;
    localparam int LVL_W  = CNT_W + 1;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(2 ** (REF_W - 1));

    logic signed [REF_W-1:0] ref_q;
    logic signed [EXT_W-1:0] ref_x;
    logic [LVL_W-1:0]        cnt_x;

    // Reference capture at the valley only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (valley) begin
            ref_q <= ref_in;
        end
    end

    assign ref_x = {{2{ref_q[REF_W-1]}}, ref_q};
    assign cnt_x = {1'b0, cnt};
    assign pos_o = ~ref_q[REF_W-1];

    // One offset level and comparator per leg; the right leg uses -r.
    for (genvar leg = 0; leg < NUM_LEGS; leg++) begin : g_leg
        logic signed [EXT_W-1:0] off_s;
        logic [OFF_W-1:0]        off_u;
        logic [PROD_W-1:0]       prod;
        logic [LVL_W-1:0]        level;
        logic                    unused_off;
        logic [REF_W-1:0]        unused_lo;

        if (leg == 0) begin : g_plus
            assign off_s = HALF + ref_x;
        end else begin : g_minus
            assign off_s = HALF - ref_x;
        end

        assign off_u      = off_s[OFF_W-1:0];
        assign unused_off = off_s[EXT_W-1];
        assign prod       = PROD_W'(off_u) * PROD_W'(per);
        assign level      = prod[PROD_W-1:REF_W];
        assign unused_lo  = prod[REF_W-1:0];
        assign hi_on[leg] = (level > cnt_x);
    end

    // Magnitude comparison for the legacy scheme.
    logic signed [EXT_W-1:0] mag_s;
    logic [REF_W-1:0]        mag_u;
    logic [PROD_W-1:0]       prod_m;
    logic [LVL_W-1:0]        level_m;
    logic [1:0]              unused_mag_top;
    logic                    unused_pm_top;
    logic [REF_W-2:0]        unused_pm_lo;

    assign mag_s          = ref_x[EXT_W-1] ? -ref_x : ref_x;
    assign mag_u          = mag_s[REF_W-1:0];
    assign unused_mag_top = mag_s[EXT_W-1:REF_W];
    assign prod_m         = PROD_W'(mag_u) * PROD_W'(per);
    assign level_m        = prod_m[REF_W-1 +: LVL_W];
    assign unused_pm_top  = prod_m[PROD_W-1];
    assign unused_pm_lo   = prod_m[REF_W-2:0];
    assign mag_pwm_o      = (level_m > cnt_x);
endmodule

// File: rtl/csi_pwm_mapper.sv
// Current-source gate mapping and output register.
// Builds complementary voltage-source gates per leg. It finds the cycles
// where both uppers or both lowers are open, and closes the leg chosen by the
// reference sign for those cycles. It also builds the legacy pattern, selects
// by mode and registers the result. Outputs stay off until one valley has
// passed after reset.
module csi_pwm_mapper
    import csi_pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valley,
    input  logic                 legacy_mode,
    input  logic [NUM_LEGS-1:0]  hi_on,
    input  logic                 pos,
    input  logic                 mag_pwm,
    output logic [NUM_GATES-1:0] gate_o
);
    leg_gate_t             vsi    [NUM_LEGS];
    leg_gate_t             fresh  [NUM_LEGS];
    leg_gate_t             legacy [NUM_LEGS];
    logic [NUM_LEGS-1:0]   steer;
    logic [NUM_GATES-1:0]  gate_nxt;
    logic                  open_hi;
    logic                  open_lo;
    logic                  shoot;
    logic                  armed_q;

    // Open-circuit detection on the voltage-source pattern.
    always_comb begin
        open_hi = 1'b1;
        open_lo = 1'b1;
        for (int leg = 0; leg < NUM_LEGS; leg++) begin
            open_hi = open_hi & ~vsi[leg].hi;
            open_lo = open_lo & ~vsi[leg].lo;
        end
        shoot = open_hi | open_lo;
    end

    assign steer[0] = shoot & pos;
    assign steer[1] = shoot & ~pos;

    for (genvar leg = 0; leg < NUM_LEGS; leg++) begin : g_map
        logic home;

        // Complementary voltage-source gates of this leg.
        assign vsi[leg].hi = hi_on[leg];
        assign vsi[leg].lo = ~hi_on[leg];

        // Normal scheme: close the whole leg on a steered shoot-through.
        assign fresh[leg].hi = vsi[leg].hi | steer[leg];
        assign fresh[leg].lo = vsi[leg].lo | steer[leg];

        // Legacy scheme: the home leg holds its upper and idles on ~pwm.
        if (leg == 0) begin : g_home_l
            assign home = pos;
        end else begin : g_home_r
            assign home = ~pos;
        end
        assign legacy[leg].hi = home;
        assign legacy[leg].lo = home ? ~mag_pwm : mag_pwm;

        assign gate_nxt[2*leg]   = legacy_mode ? legacy[leg].hi : fresh[leg].hi;
        assign gate_nxt[2*leg+1] = legacy_mode ? legacy[leg].lo : fresh[leg].lo;
    end

    // Enable flag: set by the first valley after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (valley) begin
            armed_q <= 1'b1;
        end
    end

    // Output register, held off until enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o <= '0;
        end else if (armed_q) begin
            gate_o <= gate_nxt;
        end else begin
            gate_o <= '0;
        end
    end
endmodule

// File: rtl/csi_pwm_gen.sv
// Top of the single-phase current-source bridge modulator.
// Connects carrier, comparison and gate mapping. Assumes a reference in
// two's complement and a period word of at least 2 (smaller values are
// clamped). Gate bit order: S1, S2, S3, S4 from bit 0 upward.
module csi_pwm_gen
    import csi_pwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    legacy_mode,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [CNT_W-1:0]        period,
    output logic [NUM_GATES-1:0]    gate
);
    logic [CNT_W-1:0]    carrier_cnt;
    logic [CNT_W-1:0]    carrier_per;
    logic                carrier_valley;
    logic [NUM_LEGS-1:0] leg_hi_on;
    logic                ref_pos;
    logic                mag_pwm;

    csi_pwm_carrier #(
        .CNT_W(CNT_W)
    ) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_in(period),
        .cnt_o    (carrier_cnt),
        .per_o    (carrier_per),
        .valley_o (carrier_valley)
    );

    csi_pwm_compare #(
        .REF_W(REF_W),
        .CNT_W(CNT_W)
    ) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .valley   (carrier_valley),
        .ref_in   (ref_sample),
        .per      (carrier_per),
        .cnt      (carrier_cnt),
        .hi_on    (leg_hi_on),
        .pos_o    (ref_pos),
        .mag_pwm_o(mag_pwm)
    );

    csi_pwm_mapper u_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .valley     (carrier_valley),
        .legacy_mode(legacy_mode),
        .hi_on      (leg_hi_on),
        .pos        (ref_pos),
        .mag_pwm    (mag_pwm),
        .gate_o     (gate)
    );
endmodule

// File: rtl/csi_pwm_chk.sv
// Property checker for csi_pwm_gen, attached by bind.
// Observes the gate outputs, the mode input and the carrier state.
module csi_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             legacy_mode,
    input logic [3:0]       gate,
    input logic             valley,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per
);
    // R1: the carrier moves by exactly one step per clock.
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cnt == $past(cnt) + CNT_W'(1)) || ($past(cnt) == cnt + CNT_W'(1))));

    // R1: the count never passes the captured period.
    a_r1_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        !valley |-> (cnt <= per));

    // R2: the captured period only changes after a valley.
    a_r2_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valley |=> $stable(per));

    // R3: gates are off in the first cycle after release.
    a_r3_off_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate == 4'b0000));

    // R6: once enabled, an upper and a lower device always conduct.
    a_r6_path_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
        (gate != 4'b0000) |-> ((gate[0] | gate[2]) && (gate[1] | gate[3])));

    // R6: once enabled, the gates never all drop off again.
    a_r6_stays_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (gate != 4'b0000) |=> (gate != 4'b0000));

    // R5: two uppers on together means one whole leg is closed.
    a_r5_leg_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(legacy_mode) && (gate[0] && gate[2]))
            |-> ((gate[1:0] == 2'b11) || (gate[3:2] == 2'b11)));

    // R7: legacy mode has exactly one upper and one lower on.
    a_r7_legacy_single: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(legacy_mode) && (gate != 4'b0000))
            |-> (($countones({gate[2], gate[0]}) == 1) && ($countones({gate[3], gate[1]}) == 1)));
endmodule

bind csi_pwm_gen csi_pwm_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacy_mode(legacy_mode),
    .gate       (gate),
    .valley     (carrier_valley),
    .cnt        (carrier_cnt),
    .per        (carrier_per)
);

// File: tb/csi_pwm_gen_tb_top.sv
// Self-checking bench: a cycle model built from the requirements, plus
// fundamental-period on-time and transition counts.
module csi_pwm_gen_tb_top;
    localparam int REF_W = 12;
    localparam int CNT_W = 16;
    localparam int NS    = 20;
    localparam int P0    = 25;
    localparam int HALF  = 2 ** (REF_W - 1);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    legacy_mode = 1'b0;
    logic signed [REF_W-1:0] ref_sample = '0;
    logic [CNT_W-1:0]        period = CNT_W'(P0);
    logic [3:0]              gate;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;
    bit hold_ref   = 1'b0;
    int sidx       = 0;

    // Model state
    int         m_c   = 0;
    int         m_p   = 0;
    int         m_r   = 0;
    bit         m_up  = 1'b1;
    bit         m_arm = 1'b0;
    logic [3:0] m_exp = 4'b0000;
    int         cyc   = 0;

    always #10 clk = ~clk;

    csi_pwm_gen #(
        .REF_W(REF_W),
        .CNT_W(CNT_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .legacy_mode(legacy_mode),
        .ref_sample (ref_sample),
        .period     (period),
        .gate       (gate)
    );

    function automatic int sample_at(int k);
        real a;
        a = (real'(HALF) - 1.0) * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / real'(NS));
        return $rtoi(a);
    endfunction

    function automatic int legal_period(int p);
        return (p < 2) ? 2 : p;
    endfunction

    // Expected gates from R4, R5 and R7 for count c, reference r, period p.
    function automatic logic [3:0] expect_gates(int c, int r, int p, logic leg_mode);
        int  lvl_l, lvl_r, lvl_m, mag;
        bit  g1, g2, g3, g4, pos, sht, w;
        logic [3:0] s;
        lvl_l = ((HALF + r) * p) / (2 ** REF_W);
        lvl_r = ((HALF - r) * p) / (2 ** REF_W);
        g1 = (lvl_l > c);
        g3 = (lvl_r > c);
        g2 = !g1;
        g4 = !g3;
        pos = (r >= 0);
        sht = (!g1 && !g3) || (!g2 && !g4);
        mag = (r < 0) ? -r : r;
        lvl_m = (mag * p) / HALF;
        w = (lvl_m > c);
        if (leg_mode) begin
            if (pos) s = {w, 1'b0, !w, 1'b1};
            else     s = {!w, 1'b1, w, 1'b0};
        end else begin
            s[0] = g1 | (sht & pos);
            s[1] = g2 | (sht & pos);
            s[2] = g3 | (sht & !pos);
            s[3] = g4 | (sht & !pos);
        end
        return s;
    endfunction

    // Cycle model of carrier, capture and output register (R1, R2, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_up = 1'b1; m_p = 0; m_r = 0; m_arm = 1'b0;
            m_exp = 4'b0000; cyc = 0;
        end else begin
            int  pe;
            bit  vly;
            m_exp = m_arm ? expect_gates(m_c, m_r, m_p, legacy_mode) : 4'b0000;
            vly = (m_c == 0);
            pe  = vly ? legal_period(int'(period)) : m_p;
            if (vly) begin
                m_p = pe;
                m_r = int'(ref_sample);
                m_arm = 1'b1;
            end
            if (m_up) begin
                m_c++;
                if (m_c >= pe) m_up = 1'b0;
            end else begin
                m_c--;
                if (m_c == 0) m_up = 1'b1;
            end
            cyc++;
        end
    end

    // Reference driver: next sine sample at each carrier top (R2 stimulus).
    always @(negedge clk) begin
        if (rst_n && !hold_ref && m_arm && !m_up && (m_c == m_p)) begin
            sidx++;
            ref_sample = REF_W'(sample_at(sidx));
        end
    end

    task automatic report_fail(string req, int act, int exp);
        mismatched++;
        $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    endtask

    // One cycle: model comparison and conduction invariant.
    task automatic step(string req);
        @(negedge clk);
        compared++;
        if (gate !== m_exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, gate, m_exp, cyc);
        end
        if (cyc >= 2) begin
            compared++;
            if (!((gate[0] | gate[2]) && (gate[1] | gate[3])))
                report_fail("R6 path", int'(gate), 15);
        end
    endtask

    initial begin
        int on_t[4];
        int edges[4];
        logic [3:0] prev;
        int lo, hi;

        ref_sample = REF_W'(sample_at(0));
        // R3: gates off throughout reset.
        repeat (4) begin
            @(negedge clk);
            compared++;
            if (gate !== 4'b0000) report_fail("R3 reset", int'(gate), 0);
        end
        rst_n = 1'b1;
        // R3: off in the first cycle after release.
        @(negedge clk);
        compared++;
        if (gate !== 4'b0000) report_fail("R3 release", int'(gate), 0);

        // R4 R5 R10: normal mode against the model over a first fundamental.
        while (cyc < 1002) step("R4 R5 R10 normal");

        // R8: on-time balance over one full fundamental.
        for (int i = 0; i < 4; i++) on_t[i] = 0;
        while (cyc < 2002) begin
            step("R4 R5 normal window");
            for (int i = 0; i < 4; i++) on_t[i] += int'(gate[i]);
        end
        lo = on_t[0]; hi = on_t[0];
        for (int i = 1; i < 4; i++) begin
            if (on_t[i] < lo) lo = on_t[i];
            if (on_t[i] > hi) hi = on_t[i];
        end
        compared++;
        if ((hi - lo) > 2 * P0) report_fail("R8 on-time spread", hi - lo, 2 * P0);
        compared++;
        if (on_t[0] == 0) report_fail("R8 S1 on-time", on_t[0], 1);

        // R7: legacy mode against the model; R9: upper transitions.
        legacy_mode = 1'b1;
        while (cyc < 2025) step("R7 legacy");
        for (int i = 0; i < 4; i++) edges[i] = 0;
        prev = gate;
        while (cyc < 3025) begin
            step("R7 legacy window");
            for (int i = 0; i < 4; i++) if (gate[i] != prev[i]) edges[i]++;
            prev = gate;
        end
        compared++;
        if (edges[0] != 2) report_fail("R9 S1 transitions", edges[0], 2);
        compared++;
        if (edges[2] != 2) report_fail("R9 S3 transitions", edges[2], 2);
        compared++;
        if (edges[1] <= 2) report_fail("R7 S2 modulated", edges[1], 3);

        // R2: period change in mid-carrier, taken at the next valley only.
        legacy_mode = 1'b0;
        repeat (7) step("R2 settle");
        period = CNT_W'(10);
        repeat (400) step("R2 period change");

        // R1: period word below 2 is clamped.
        period = CNT_W'(1);
        repeat (200) step("R1 clamp");

        // R4: extreme references held, both modes.
        period = CNT_W'(8);
        hold_ref = 1'b1;
        ref_sample = REF_W'(-HALF);
        repeat (100) step("R4 negative full scale");
        ref_sample = REF_W'(HALF - 1);
        repeat (100) step("R4 positive full scale");
        legacy_mode = 1'b1;
        repeat (100) step("R7 positive full scale");
        ref_sample = REF_W'(-HALF);
        repeat (100) step("R7 negative full scale");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule